// File: doc/BRIEF.md
# Flash block-erase sequencer

This block controls block erasure of a small byte-wide flash array and contains a register model of that array. Firmware erases a block in three steps. It writes the control register with the erase-enable bit and a two-bit size code. It then writes any value to any array address, which records the target. Finally it raises and lowers the high-voltage enable and clears erase-enable.

The block derives an aligned erase window from the recorded offset and the recorded size code. It times the high-voltage hold, the discharge interval and the read-recovery interval in clock cycles. When erase-enable is cleared after discharge, every byte in the window becomes 0xFF. This happens only if two conditions hold: the high-voltage enable stayed on for the full hold time, and the window does not reach the protected area.

Steps taken out of order end the sequence without touching the array and set a sticky error flag. Bus transactions that are not part of the sequence may come between its steps without ending it. From the moment high voltage is raised until recovery has passed, array reads return 0x00 and a not-ready flag is raised.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the control, protect and status registers read 0x00, `hv_on` and `rd_not_ready` are low, and the array byte at offset k reads (k mod 256) with bit 0 cleared.
- R2: Register map.
  - 0x7000 is the control register: bit0 erase-enable, bits 2:1 size code, bit3 high-voltage enable.
  - 0x7001 is the protect boundary.
  - 0x7002 is the status register: bit0 hold-time met, bit1 sequence error, bit2 not-ready.
  - The array occupies 0x7800 to 0x7FFF, and offset = address − 0x7800.
- R3: The size code selects the aligned window that contains the recorded offset.
  - 00 selects all 2048 bytes.
  - 01 selects a 1024-byte half.
  - 10 selects 64 bytes.
  - 11 selects one 8-byte row.
  - Bytes outside the window never change.
- R4: The first array write while armed records its offset and the current size code, and its data is ignored. Array writes at any other time do not change the array.
- R5: The status bit hold-time met becomes 1 once high voltage has been on for T_ERASE (20) cycles. If high voltage is dropped earlier, the sequence completes without changing the array.
- R6: A sequence completed in order, with the hold time met, sets every byte of the window to 0xFF on the edge that sees erase-enable cleared.
- R7: Register reads and further array writes between steps do not end the sequence, and a second array write does not move the recorded target.
- R8: With protect value P≠0, offsets at or above 8·P are protected. An erase whose window reaches them leaves the array unchanged. P=0 protects nothing.
- R9: Each of the following aborts the sequence, sets the sequence-error bit and clears the control register, and the array is left unchanged:
  - setting high voltage before a target is recorded;
  - clearing erase-enable while high voltage is on;
  - clearing erase-enable before T_KILL (5) cycles of discharge.
- R10: The sequence-error bit stays set until status is written with bit1 = 1.
- R11: From the edge that raises high voltage until T_HVD (4) cycles after erase-enable is cleared, array reads return 0x00 and `rd_not_ready` is high. After that, array data returns.
- R12: `hv_on` is high exactly while the high-voltage hold is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus transaction valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| hv_on | output | 1 | High-voltage pump enable |
| rd_not_ready | output | 1 | Array reads are blocked |

## Verification
Erases are run with every size code at unaligned target offsets. Scanning the whole array afterwards separates a correct window from one that is misaligned, too wide or too narrow. A short high-voltage hold, and windows just below and just touching the protect boundary, show that timing and protection gate the write-back and not the sequence itself. Three distinct out-of-order step patterns check abort and the sticky flag, and interleaved reads and extra array writes show that unrelated traffic neither ends the sequence nor moves its target.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LATCHED,
        ST_HV,
        ST_KILL,
        ST_WAIT_CLR,
        ST_RECOVER
    } seq_state_e;

    // control register layout: bit3 hv_en, bits2:1 size, bit0 erase_en
    typedef struct packed {
        logic       hv_en;
        logic [1:0] size;
        logic       erase_en;
    } ctrl_t;

    localparam logic [1:0] SZ_ALL   = 2'b00;
    localparam logic [1:0] SZ_HALF  = 2'b01;
    localparam logic [1:0] SZ_GROUP = 2'b10;
    localparam logic [1:0] SZ_ROW   = 2'b11;

endpackage

// File: rtl/fe_bus_decode.sv
module fe_bus_decode #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned ARRAY_BASE  = 32'h7800,
    parameter int unsigned ARRAY_BYTES = 2048,
    parameter int unsigned REG_BASE    = 32'h7000,
    parameter int unsigned OFF_W       = $clog2(ARRAY_BYTES)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              arr_hit,
    output logic [OFF_W-1:0]  arr_off,
    output logic              hit_ctrl,
    output logic              hit_prot,
    output logic              hit_stat
);

    localparam logic [ADDR_W:0]   ARR_LO = (ADDR_W+1)'(ARRAY_BASE);
    localparam logic [ADDR_W:0]   ARR_HI = (ADDR_W+1)'(ARRAY_BASE + ARRAY_BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(REG_BASE + 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + 2);

    always_comb begin
        arr_hit  = ({1'b0, bus_addr} >= ARR_LO) && ({1'b0, bus_addr} < ARR_HI);
        // array base is aligned to its size, so the low bits are the offset
        arr_off  = bus_addr[OFF_W-1:0];
        hit_ctrl = (bus_addr == A_CTRL);
        hit_prot = (bus_addr == A_PROT);
        hit_stat = (bus_addr == A_STAT);
    end

endmodule

// File: rtl/fe_erase_range.sv
module fe_erase_range
    import flash_erase_pkg::*;
#(
    parameter int unsigned OFF_W      = 11,
    parameter int unsigned ROW_BYTES  = 8,
    parameter int unsigned GROUP_ROWS = 8,
    parameter int unsigned PROT_W     = OFF_W - $clog2(ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  lat_off,
    input  logic [1:0]        lat_size,
    input  logic [PROT_W-1:0] prot,
    output logic [OFF_W-1:0]  lo,
    output logic [OFF_W-1:0]  hi,
    output logic              blocked
);

    localparam int unsigned ROW_LSB  = $clog2(ROW_BYTES);
    localparam int unsigned GRP_LSB  = $clog2(ROW_BYTES * GROUP_ROWS);
    localparam int unsigned HALF_LSB = OFF_W - 1;

    localparam logic [OFF_W-1:0] M_ROW  = OFF_W'((1 << ROW_LSB) - 1);
    localparam logic [OFF_W-1:0] M_GRP  = OFF_W'((1 << GRP_LSB) - 1);
    localparam logic [OFF_W-1:0] M_HALF = OFF_W'((1 << HALF_LSB) - 1);
    localparam logic [OFF_W-1:0] M_ALL  = '1;

    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] bound;

    always_comb begin
        unique case (lat_size)
            SZ_ALL:   mask = M_ALL;
            SZ_HALF:  mask = M_HALF;
            SZ_GROUP: mask = M_GRP;
            default:  mask = M_ROW;
        endcase
        lo      = lat_off & ~mask;
        hi      = lat_off | mask;
        bound   = {prot, {ROW_LSB{1'b0}}};
        blocked = (prot != '0) && (hi >= bound);
    end

    // R3: window is a power-of-two span that contains the recorded offset
    p_span_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({1'b0, hi} - {1'b0, lo} + 1'b1) == 1);
    p_span_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo <= lat_off) && (lat_off <= hi));

endmodule

// File: rtl/fe_seq_fsm.sv
module fe_seq_fsm
    import flash_erase_pkg::*;
#(
    parameter int unsigned OFF_W   = 11,
    parameter int unsigned T_ERASE = 20,
    parameter int unsigned T_KILL  = 5,
    parameter int unsigned T_HVD   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  ctrl_t            ctrl_wdata,
    input  logic             err_clr,
    input  logic             arr_wr,
    input  logic [OFF_W-1:0] arr_off,
    input  logic             blocked,
    output ctrl_t            ctrl_q,
    output logic [OFF_W-1:0] lat_off,
    output logic [1:0]       lat_size,
    output logic             hv_met,
    output logic             seq_err,
    output logic             not_ready,
    output logic             hv_on,
    output logic             do_erase
);

    localparam int unsigned T_MAX = (T_ERASE > T_KILL) ?
        ((T_ERASE > T_HVD) ? T_ERASE : T_HVD) :
        ((T_KILL > T_HVD) ? T_KILL : T_HVD);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] C_ERASE_END = CNT_W'(T_ERASE - 1);
    localparam logic [CNT_W-1:0] C_ERASE_SAT = CNT_W'(T_ERASE);
    localparam logic [CNT_W-1:0] C_KILL_END  = CNT_W'(T_KILL - 1);
    localparam logic [CNT_W-1:0] C_HVD_END   = CNT_W'(T_HVD - 1);

    typedef struct packed {
        seq_state_e       st;
        ctrl_t            ctrl;
        logic [OFF_W-1:0] off;
        logic [1:0]       size;
        logic [CNT_W-1:0] cnt;
        logic             met;
        logic             err;
    } seq_s;

    seq_s seq_d, seq_q;
    logic abort_d;
    logic erase_d;

    always_comb begin
        seq_d   = seq_q;
        abort_d = 1'b0;
        erase_d = 1'b0;
        if (ctrl_wr) seq_d.ctrl = ctrl_wdata;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    if (ctrl_wdata.hv_en)         abort_d = 1'b1;
                    else if (ctrl_wdata.erase_en) seq_d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (ctrl_wr) begin
                    if (ctrl_wdata.hv_en)          abort_d = 1'b1;
                    else if (!ctrl_wdata.erase_en) seq_d.st = ST_IDLE;
                end else if (arr_wr) begin
                    seq_d.st   = ST_LATCHED;
                    seq_d.off  = arr_off;
                    seq_d.size = seq_q.ctrl.size;
                end
            end
            ST_LATCHED: begin
                if (ctrl_wr) begin
                    if (!ctrl_wdata.erase_en) begin
                        if (ctrl_wdata.hv_en) abort_d = 1'b1;
                        else                  seq_d.st = ST_IDLE;
                    end else if (ctrl_wdata.hv_en) begin
                        seq_d.st  = ST_HV;
                        seq_d.cnt = '0;
                        seq_d.met = 1'b0;
                    end
                end
            end
            ST_HV: begin
                if (seq_q.cnt != C_ERASE_SAT) seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == C_ERASE_END) seq_d.met = 1'b1;
                if (ctrl_wr) begin
                    if (!ctrl_wdata.erase_en) abort_d = 1'b1;
                    else if (!ctrl_wdata.hv_en) begin
                        seq_d.st  = ST_KILL;
                        seq_d.cnt = '0;
                    end
                end
            end
            ST_KILL: begin
                if (ctrl_wr && (!ctrl_wdata.erase_en || ctrl_wdata.hv_en)) begin
                    abort_d = 1'b1;
                end else if (seq_q.cnt == C_KILL_END) begin
                    seq_d.st  = ST_WAIT_CLR;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_WAIT_CLR: begin
                if (ctrl_wr) begin
                    if (ctrl_wdata.hv_en) abort_d = 1'b1;
                    else if (!ctrl_wdata.erase_en) begin
                        seq_d.st  = ST_RECOVER;
                        seq_d.cnt = '0;
                        erase_d   = seq_q.met && !blocked;
                    end
                end
            end
            ST_RECOVER: begin
                if (seq_q.cnt == C_HVD_END) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                    seq_d.met = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (err_clr) seq_d.err = 1'b0;
        if (abort_d) begin
            seq_d.st   = ST_IDLE;
            seq_d.ctrl = '0;
            seq_d.cnt  = '0;
            seq_d.met  = 1'b0;
            seq_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, ctrl: '0, off: '0, size: '0,
                       cnt: '0, met: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        ctrl_q    = seq_q.ctrl;
        lat_off   = seq_q.off;
        lat_size  = seq_q.size;
        hv_met    = seq_q.met;
        seq_err   = seq_q.err;
        hv_on     = (seq_q.st == ST_HV);
        not_ready = (seq_q.st == ST_HV) || (seq_q.st == ST_KILL) ||
                    (seq_q.st == ST_WAIT_CLR) || (seq_q.st == ST_RECOVER);
        do_erase  = erase_d;
    end

    // R9: the high-voltage phase is only entered from a recorded target
    p_hv_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HV && $past(seq_q.st) != ST_HV) |-> $past(seq_q.st) == ST_LATCHED);
    // R10: error flag holds unless explicitly cleared
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.err && !err_clr) |=> seq_q.err);
    // R12: pump only runs while both enables are held in the register
    p_hv_enables_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hv_on |-> (seq_q.ctrl.hv_en && seq_q.ctrl.erase_en));

endmodule

// File: rtl/fe_byte_array.sv
module fe_byte_array #(
    parameter int unsigned BYTES = 2048,
    parameter int unsigned OFF_W = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_erase,
    input  logic [OFF_W-1:0] lo,
    input  logic [OFF_W-1:0] hi,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data
);

    logic [7:0] mem_q [BYTES];

    // storage array: registered directly, reset loads a fixed pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'(i) & 8'hFE;
        end else if (do_erase) begin
            for (int i = 0; i < BYTES; i++) begin
                if ((OFF_W'(i) >= lo) && (OFF_W'(i) <= hi)) mem_q[i] <= 8'hFF;
            end
        end
    end

    assign rd_data = mem_q[rd_off];

    // R6: both ends of the window hold the erased value after an erase
    p_erase_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase |=> (mem_q[$past(lo)] == 8'hFF) && (mem_q[$past(hi)] == 8'hFF));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned ARRAY_BASE  = 32'h7800,
    parameter int unsigned ARRAY_BYTES = 2048,
    parameter int unsigned REG_BASE    = 32'h7000,
    parameter int unsigned ROW_BYTES   = 8,
    parameter int unsigned GROUP_ROWS  = 8,
    parameter int unsigned T_ERASE     = 20,
    parameter int unsigned T_KILL      = 5,
    parameter int unsigned T_HVD       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              hv_on,
    output logic              rd_not_ready
);

    localparam int unsigned OFF_W   = $clog2(ARRAY_BYTES);
    localparam int unsigned ROW_LSB = $clog2(ROW_BYTES);
    localparam int unsigned PROT_W  = OFF_W - ROW_LSB;

    logic              arr_hit, hit_ctrl, hit_prot, hit_stat;
    logic [OFF_W-1:0]  arr_off, lat_off, lo, hi;
    logic [1:0]        lat_size;
    logic              blocked, hv_met, seq_err, not_ready, do_erase;
    logic              wr_en;
    ctrl_t             ctrl_q;
    logic [7:0]        mem_rd;
    logic [PROT_W-1:0] prot_d, prot_q;

    fe_bus_decode #(
        .ADDR_W(ADDR_W), .ARRAY_BASE(ARRAY_BASE), .ARRAY_BYTES(ARRAY_BYTES),
        .REG_BASE(REG_BASE), .OFF_W(OFF_W)
    ) u_dec (
        .bus_addr(bus_addr), .arr_hit(arr_hit), .arr_off(arr_off),
        .hit_ctrl(hit_ctrl), .hit_prot(hit_prot), .hit_stat(hit_stat)
    );

    assign wr_en = bus_sel && bus_wr;

    fe_seq_fsm #(
        .OFF_W(OFF_W), .T_ERASE(T_ERASE), .T_KILL(T_KILL), .T_HVD(T_HVD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_en && hit_ctrl),
        .ctrl_wdata(ctrl_t'(bus_wdata[3:0])),
        .err_clr(wr_en && hit_stat && bus_wdata[1]),
        .arr_wr(wr_en && arr_hit),
        .arr_off(arr_off),
        .blocked(blocked),
        .ctrl_q(ctrl_q), .lat_off(lat_off), .lat_size(lat_size),
        .hv_met(hv_met), .seq_err(seq_err), .not_ready(not_ready),
        .hv_on(hv_on), .do_erase(do_erase)
    );

    fe_erase_range #(
        .OFF_W(OFF_W), .ROW_BYTES(ROW_BYTES), .GROUP_ROWS(GROUP_ROWS), .PROT_W(PROT_W)
    ) u_range (
        .clk(clk), .rst_n(rst_n), .lat_off(lat_off), .lat_size(lat_size),
        .prot(prot_q), .lo(lo), .hi(hi), .blocked(blocked)
    );

    fe_byte_array #(.BYTES(ARRAY_BYTES), .OFF_W(OFF_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .do_erase(do_erase), .lo(lo), .hi(hi),
        .rd_off(arr_off), .rd_data(mem_rd)
    );

    always_comb begin
        prot_d = prot_q;
        if (wr_en && hit_prot) prot_d = PROT_W'(bus_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (arr_hit)       bus_rdata = not_ready ? 8'h00 : mem_rd;
        else if (hit_ctrl) bus_rdata = {4'b0000, ctrl_q};
        else if (hit_prot) bus_rdata = 8'(prot_q);
        else if (hit_stat) bus_rdata = {5'b00000, not_ready, seq_err, hv_met};
    end

    assign rd_not_ready = not_ready;

    // R11: a blocked array read never returns stored data
    p_blocked_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && arr_hit && rd_not_ready) |-> bus_rdata == 8'h00);

endmodule

// File: tb/flash_erase_ctrl_tb_top.sv
module flash_erase_ctrl_tb_top;

    localparam int T_ERASE = 20;
    localparam int T_KILL  = 5;
    localparam int T_HVD   = 4;
    localparam int NBYTES  = 2048;
    localparam logic [15:0] A_CTRL = 16'h7000;
    localparam logic [15:0] A_PROT = 16'h7001;
    localparam logic [15:0] A_STAT = 16'h7002;
    localparam logic [15:0] A_ARR  = 16'h7800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        hv_on, rd_not_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NBYTES];

    always #10 clk = ~clk;

    flash_erase_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hv_on(hv_on), .rd_not_ready(rd_not_ready)
    );

    function automatic logic [7:0] mk_ctrl(input logic hv, input logic [1:0] sz, input logic er);
        return {4'b0000, hv, sz, er};
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic model_erase(input logic [1:0] sz, input int off);
        int span;
        int base;
        span = (sz == 2'b00) ? 2048 : (sz == 2'b01) ? 1024 : (sz == 2'b10) ? 64 : 8;
        base = (off / span) * span;
        for (int i = base; i < base + span; i++) model[i] = 8'hFF;
    endtask

    task automatic scan(input string req);
        logic [7:0] v;
        int bad = 0;
        int first = -1;
        logic [7:0] fa = 0;
        logic [7:0] fe = 0;
        for (int i = 0; i < NBYTES; i++) begin
            bus_read(A_ARR + 16'(i), v);
            if (v !== model[i]) begin
                if (first < 0) begin first = i; fa = v; fe = model[i]; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s array offset %0d actual=%h expected=%h (%0d bytes differ)",
                     req, first, fa, fe, bad);
        end
    endtask

    // complete erase sequence; checks status, hv_on and read blocking on the way
    task automatic run_seq(input logic [1:0] sz, input int off, input int hold, input logic interleave);
        logic [7:0] v;
        bus_write(A_CTRL, mk_ctrl(1'b0, sz, 1'b1));
        if (interleave) bus_read(A_PROT, v);
        bus_write(A_ARR + 16'(off), 8'h3C);
        if (interleave) begin
            // R7: a second array write must not move the recorded target
            bus_write(A_ARR + 16'((off + 1024) % NBYTES), 8'h00);
            bus_read(A_STAT, v);
            check(v == 8'h00, "R7 status between steps", {8'h0, v}, 16'h0000);
        end
        bus_write(A_CTRL, mk_ctrl(1'b1, sz, 1'b1));
        check(hv_on == 1'b1, "R12 hv_on during hold", {15'h0, hv_on}, 16'h0001);
        check(rd_not_ready == 1'b1, "R11 not ready during hold", {15'h0, rd_not_ready}, 16'h0001);
        repeat (hold) @(negedge clk);
        bus_read(A_STAT, v);
        check(v[0] == (hold >= T_ERASE), "R5 hold-time met bit", {15'h0, v[0]},
              {15'h0, hold >= T_ERASE});
        bus_write(A_CTRL, mk_ctrl(1'b0, sz, 1'b1));
        check(hv_on == 1'b0, "R12 hv_on after drop", {15'h0, hv_on}, 16'h0000);
        repeat (T_KILL + 2) @(negedge clk);
        bus_write(A_CTRL, mk_ctrl(1'b0, sz, 1'b0));
        bus_read(A_ARR + 16'(off), v);
        check(v == 8'h00 && rd_not_ready, "R11 read during recovery", {7'h0, rd_not_ready, v}, 16'h0100);
        repeat (T_HVD + 1) @(negedge clk);
        check(rd_not_ready == 1'b0, "R11 ready after recovery", {15'h0, rd_not_ready}, 16'h0000);
        bus_read(A_STAT, v);
        check(v[1] == 1'b0, "R9 no error on ordered sequence", {8'h0, v}, 16'h0000);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(A_CTRL, v); check(v == 8'h00, "R1 ctrl reset", {8'h0, v}, 16'h0);
        bus_read(A_PROT, v); check(v == 8'h00, "R1 prot reset", {8'h0, v}, 16'h0);
        bus_read(A_STAT, v); check(v == 8'h00, "R1 R2 stat reset", {8'h0, v}, 16'h0);
        check(!hv_on && !rd_not_ready, "R1 flags reset", {14'h0, hv_on, rd_not_ready}, 16'h0);
        scan("R1 preload");
    endtask

    task automatic t_ignored_write;
        logic [7:0] v;
        bus_write(A_ARR + 16'd5, 8'h00);
        bus_read(A_ARR + 16'd5, v);
        check(v == 8'h04, "R4 idle array write ignored", {8'h0, v}, 16'h0004);
    endtask

    task automatic t_row;
        run_seq(2'b11, 291, T_ERASE + 2, 1'b1);
        model_erase(2'b11, 291);
        scan("R3 R6 R7 row erase");
    endtask

    task automatic t_group;
        run_seq(2'b10, 677, T_ERASE + 2, 1'b0);
        model_erase(2'b10, 677);
        scan("R3 R6 group erase");
    endtask

    task automatic t_short_hold;
        run_seq(2'b01, 1040, 3, 1'b0);
        scan("R5 short hold leaves array");
    endtask

    task automatic t_protect;
        logic [7:0] v;
        bus_write(A_PROT, 8'hF0);
        bus_read(A_PROT, v); check(v == 8'hF0, "R2 R8 prot readback", {8'h0, v}, 16'h00F0);
        run_seq(2'b11, 1925, T_ERASE + 2, 1'b0);
        scan("R8 protected row kept");
        run_seq(2'b11, 1914, T_ERASE + 2, 1'b0);
        model_erase(2'b11, 1914);
        scan("R8 row below boundary erased");
        bus_write(A_PROT, 8'h00);
    endtask

    task automatic t_order_errors;
        logic [7:0] v;
        // HVEN without a recorded target
        bus_write(A_CTRL, mk_ctrl(1'b0, 2'b11, 1'b1));
        bus_write(A_CTRL, mk_ctrl(1'b1, 2'b11, 1'b1));
        bus_read(A_STAT, v); check(v[1] == 1'b1, "R9 hv before target", {8'h0, v}, 16'h0002);
        bus_read(A_CTRL, v); check(v == 8'h00, "R9 ctrl cleared on abort", {8'h0, v}, 16'h0000);
        repeat (5) @(negedge clk);
        bus_read(A_STAT, v); check(v[1] == 1'b1, "R10 error sticky", {8'h0, v}, 16'h0002);
        bus_write(A_STAT, 8'h02);
        bus_read(A_STAT, v); check(v[1] == 1'b0, "R10 error cleared", {8'h0, v}, 16'h0000);
        // erase-enable cleared while high voltage is on
        bus_write(A_CTRL, mk_ctrl(1'b0, 2'b11, 1'b1));
        bus_write(A_ARR + 16'd100, 8'h11);
        bus_write(A_CTRL, mk_ctrl(1'b1, 2'b11, 1'b1));
        repeat (T_ERASE + 2) @(negedge clk);
        bus_write(A_CTRL, mk_ctrl(1'b1, 2'b11, 1'b0));
        bus_read(A_STAT, v); check(v == 8'h02, "R9 erase cleared under HV", {8'h0, v}, 16'h0002);
        bus_read(A_ARR + 16'd100, v); check(v == model[100], "R9 array kept (HV)", {8'h0, v}, {8'h0, model[100]});
        bus_write(A_STAT, 8'h02);
        // erase-enable cleared during discharge
        bus_write(A_CTRL, mk_ctrl(1'b0, 2'b11, 1'b1));
        bus_write(A_ARR + 16'd200, 8'h11);
        bus_write(A_CTRL, mk_ctrl(1'b1, 2'b11, 1'b1));
        repeat (T_ERASE + 2) @(negedge clk);
        bus_write(A_CTRL, mk_ctrl(1'b0, 2'b11, 1'b1));
        bus_write(A_CTRL, mk_ctrl(1'b0, 2'b11, 1'b0));
        bus_read(A_STAT, v); check(v == 8'h02, "R9 erase cleared in discharge", {8'h0, v}, 16'h0002);
        bus_read(A_ARR + 16'd200, v); check(v == model[200], "R9 array kept (discharge)", {8'h0, v}, {8'h0, model[200]});
        bus_write(A_STAT, 8'h02);
    endtask

    task automatic t_half;
        run_seq(2'b01, 1100, T_ERASE + 2, 1'b0);
        model_erase(2'b01, 1100);
        scan("R3 R6 half erase");
    endtask

    task automatic t_full;
        run_seq(2'b00, 0, T_ERASE + 2, 1'b0);
        model_erase(2'b00, 0);
        scan("R3 R6 full erase");
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) model[i] = 8'(i) & 8'hFE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ignored_write();
        t_row();
        t_group();
        t_short_hold();
        t_protect();
        t_order_errors();
        t_half();
        t_full();
        finish_run();
    end

endmodule